// File: doc/BRIEF.md
# Address-Sequence Recall Command Detector

This block sits between a host's parallel bus and an 8K x 8 volatile memory. It has a persistent backing memory beside it. The block watches read cycles framed by the chip enable. When a fixed series of six read addresses arrives in order, it treats the series as a hidden command and starts a recall.

The recall runs in two passes. The first pass writes zero to every volatile location. The second pass reads each word from the backing memory, which answers one clock after each request. It then writes that word into the same volatile location. While the recall runs, the block raises a busy flag and shuts the host out. When the last word lands, the block pulses a done flag and returns the array to ordinary host reads and writes.

Outside a recall, host cycles pass straight through to the volatile memory. The five reads before the last one in the series return ordinary data.

Top module: `recall_cmd_ctrl`

## Requirements
- R1: A read cycle is `ce_n` low for one or more clocks with `we_n` high throughout. The cycle ends at the first clock where `ce_n` is sampled high. Six such cycles in order, at addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0E, start a recall. `busy` is high from the clock after the edge that sampled the end of the sixth cycle.
- R2: A read at an address other than the next expected one sends the tracker back to step zero. If that read is at 0x0000, it counts as step one of a new attempt.
- R3: While idle, any cycle with `we_n` low while `ce_n` is low is a write. A write sends the tracker back to step zero. During that write, `mem_we` is high and the host's address and data appear on `mem_addr` and `mem_wdata`.
- R4: While idle, `mem_addr` follows `addr`, and `host_rdata` equals `mem_rdata`.
- R5: During the first 8192 busy clocks, `mem_we` is high on every clock. `mem_addr` counts up from 0x0000 to 0x1FFF, and `mem_wdata` is 0x00.
- R6: After the clearing pass, `nv_re` is high for 8192 clocks, with `nv_addr` counting up from 0x0000. The word returned on `nv_rdata` one clock after each request is written on the next clock: `mem_we` is high, `mem_addr` is that request's address and `mem_wdata` is the returned word.
- R7: `done` and `busy` are low after reset. `done` is high for exactly one clock, the clock of the final copy write. `busy` is low from the next clock. A full recall holds `busy` for 16385 clocks.
- R8: While `busy` is high, host writes never reach `mem_*` and `host_rdata` is 0x00. Host reads made during a recall do not count toward the sequence.
- R9: The backing memory port is read-only. A second recall produces the same write stream to the volatile memory as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | 13 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data to host, zero while busy |
| busy | output | 1 | Recall in progress |
| done | output | 1 | One-clock pulse on the final copy write |
| mem_addr | output | 13 | Volatile memory address |
| mem_we | output | 1 | Volatile memory write strobe |
| mem_wdata | output | 8 | Volatile memory write data |
| mem_rdata | input | 8 | Volatile memory read data |
| nv_re | output | 1 | Backing memory read request |
| nv_addr | output | 13 | Backing memory address |
| nv_rdata | input | 8 | Backing memory data, valid one clock after the request |

## Verification
The assertions assume that host inputs are synchronous to `clk` and change only between edges. They also assume that the backing memory returns data exactly one clock after `nv_re`. The bench drives every host signal on the falling edge. It models the backing memory as a register that loads a computed word on the rising edge after each request. It holds `ce_n` low for two clocks per cycle, so every cycle has a clean start and end. Host activity during a recall is deliberately overlapped with the busy window so that the lockout is exercised.

// File: rtl/recall_pkg.sv
package recall_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_COPY  = 2'd2,
    ST_FLUSH = 2'd3
  } rc_state_t;

  localparam int UNLOCK_LEN = 6;

  // Ordered unlock addresses; position in the list is the step number.
  function automatic logic [12:0] unlock_addr(input int idx);
    case (idx)
      0:       unlock_addr = 13'h0000;
      1:       unlock_addr = 13'h1555;
      2:       unlock_addr = 13'h0AAA;
      3:       unlock_addr = 13'h1FFF;
      4:       unlock_addr = 13'h10F0;
      default: unlock_addr = 13'h0F0E;
    endcase
  endfunction
endpackage

// File: rtl/seq_tracker.sv
module seq_tracker
  import recall_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int SEQ_LEN = UNLOCK_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              start
);
  localparam int STEP_W = $clog2(SEQ_LEN + 1);

  logic              ce_q;
  logic [ADDR_W-1:0] addr_lat_q, addr_lat_d;
  logic              wr_seen_q, wr_seen_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              end_evt;
  logic [ADDR_W-1:0] exp_addr, head_addr;

  always_comb begin
    end_evt    = !ce_q && ce_n;
    exp_addr   = ADDR_W'(unlock_addr(int'(step_q)));
    head_addr  = ADDR_W'(unlock_addr(0));
    addr_lat_d = ce_n ? addr_lat_q : addr;
    if (end_evt)
      wr_seen_d = 1'b0;
    else if (!ce_n && !we_n)
      wr_seen_d = 1'b1;
    else
      wr_seen_d = wr_seen_q;

    step_d = step_q;
    start  = 1'b0;
    if (!en) begin
      step_d = '0;
    end else if (end_evt) begin
      if (wr_seen_q) begin
        step_d = '0;
      end else if (addr_lat_q == exp_addr) begin
        if (step_q == STEP_W'(SEQ_LEN - 1)) begin
          start  = 1'b1;
          step_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else if (addr_lat_q == head_addr) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q       <= 1'b1;
      addr_lat_q <= '0;
      wr_seen_q  <= 1'b0;
      step_q     <= '0;
    end else begin
      ce_q       <= ce_n;
      addr_lat_q <= addr_lat_d;
      wr_seen_q  <= wr_seen_d;
      step_q     <= step_d;
    end
  end
endmodule

// File: rtl/recall_engine.sv
module recall_engine
  import recall_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] nv_rdata,
  output logic              busy,
  output logic              done,
  output logic              nv_re,
  output logic [ADDR_W-1:0] nv_addr,
  output logic              eng_we,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_wdata
);
  rc_state_t         state_q, state_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic              last;

  always_comb begin
    last        = (cnt_q == '1);
    state_d     = state_q;
    cnt_d       = cnt_q;
    pend_d      = pend_q;
    pend_addr_d = pend_addr_q;
    busy        = (state_q != ST_IDLE);
    done        = 1'b0;
    nv_re       = 1'b0;
    nv_addr     = cnt_q;
    eng_we      = 1'b0;
    eng_addr    = cnt_q;
    eng_wdata   = '0;
    case (state_q)
      ST_IDLE: begin
        cnt_d  = '0;
        pend_d = 1'b0;
        if (start) state_d = ST_CLEAR;
      end
      ST_CLEAR: begin
        eng_we = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        pend_d = 1'b0;
        if (last) state_d = ST_COPY;
      end
      ST_COPY: begin
        nv_re       = 1'b1;
        eng_we      = pend_q;
        eng_addr    = pend_addr_q;
        eng_wdata   = nv_rdata;
        pend_d      = 1'b1;
        pend_addr_d = cnt_q;
        cnt_d       = cnt_q + 1'b1;
        if (last) state_d = ST_FLUSH;
      end
      default: begin
        eng_we    = pend_q;
        eng_addr  = pend_addr_q;
        eng_wdata = nv_rdata;
        done      = 1'b1;
        pend_d    = 1'b0;
        state_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      pend_q      <= pend_d;
      pend_addr_q <= pend_addr_d;
    end
  end
endmodule

// File: rtl/recall_cmd_ctrl.sv
module recall_cmd_ctrl #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              nv_re,
  output logic [ADDR_W-1:0] nv_addr,
  input  logic [DATA_W-1:0] nv_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              start;
  logic              eng_we;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  seq_tracker #(.ADDR_W(ADDR_W)) u_track (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (!busy),
    .ce_n  (ce_n),
    .we_n  (we_n),
    .addr  (addr),
    .start (start)
  );

  recall_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .nv_rdata  (nv_rdata),
    .busy      (busy),
    .done      (done),
    .nv_re     (nv_re),
    .nv_addr   (nv_addr),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata)
  );

  always_comb begin
    if (busy) begin
      mem_we     = eng_we;
      mem_addr   = eng_addr;
      mem_wdata  = eng_wdata;
      host_rdata = '0;
    end else begin
      mem_we     = !ce_n && !we_n;
      mem_addr   = addr;
      mem_wdata  = host_wdata;
      host_rdata = mem_rdata;
    end
  end
endmodule

// File: rtl/recall_cmd_ctrl_chk.sv
module recall_cmd_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              nv_re
);
  AST_BUSY_RISE_CLEARS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> (mem_we && mem_addr == '0 && mem_wdata == '0)); // R5

  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && mem_we && mem_addr == '1)); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done)); // R7

  AST_IDLE_WRITE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_we == (!ce_n && !we_n) && mem_addr == addr)); // R3

  AST_BUSY_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (host_rdata == '0)); // R8

  AST_NV_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nv_re |-> (busy && !done)); // R6
endmodule

bind recall_cmd_ctrl recall_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .we_n       (we_n),
  .addr       (addr),
  .host_rdata (host_rdata),
  .busy       (busy),
  .done       (done),
  .mem_addr   (mem_addr),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata),
  .nv_re      (nv_re)
);

// File: tb/recall_cmd_ctrl_tb.sv
module recall_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8192;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n;
  logic [12:0] addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        busy, done;
  logic [12:0] mem_addr, nv_addr;
  logic        mem_we, nv_re;
  logic [7:0]  mem_wdata, mem_rdata, nv_rdata;

  int checks = 0;
  int fails  = 0;
  int wr_idx, bad_clear, bad_copy, done_cnt, busy_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  recall_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .nv_re(nv_re), .nv_addr(nv_addr), .nv_rdata(nv_rdata)
  );

  function automatic logic [7:0] nv_word(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign mem_rdata = ~mem_addr[7:0];

  always @(posedge clk) if (nv_re) nv_rdata <= nv_word(nv_addr);

  // Write-stream monitor for the recall window
  always @(negedge clk) begin
    if (busy) begin
      busy_len++;
      if (mem_we) begin
        if (wr_idx < DEPTH) begin
          if (mem_addr != 13'(wr_idx) || mem_wdata != 8'h00) bad_clear++;
        end else begin
          if (mem_addr != 13'(wr_idx - DEPTH) || mem_wdata != nv_word(mem_addr)) bad_copy++;
        end
        wr_idx++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    wr_idx = 0; bad_clear = 0; bad_copy = 0; done_cnt = 0; busy_len = 0;
  endtask

  task automatic host_read(input logic [12:0] a, input bit chk_data);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    @(negedge clk);
    if (chk_data) chk(host_rdata == ~a[7:0] && mem_addr == a, "R4", host_rdata, ~a[7:0]);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [12:0] a, input logic [7:0] d, input bit chk_pass);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; host_wdata = d;
    @(negedge clk);
    if (chk_pass) chk(mem_we && mem_addr == a && mem_wdata == d, "R3 write forwarded", mem_wdata, d);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic first_five();
    host_read(13'h0000, 1'b1);
    host_read(13'h1555, 1'b1);
    host_read(13'h0AAA, 1'b1);
    host_read(13'h1FFF, 1'b1);
    host_read(13'h10F0, 1'b1);
  endtask

  task automatic wait_recall();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic check_recall(input string tag);
    chk(bad_clear == 0, {tag, " R5 clear stream"}, bad_clear, 0);
    chk(bad_copy == 0, {tag, " R6 copy stream"}, bad_copy, 0);
    chk(wr_idx == 2*DEPTH, {tag, " R6 write count"}, wr_idx, 2*DEPTH);
    chk(done_cnt == 1 && busy_len == 2*DEPTH + 1, {tag, " R7 done/busy length"}, busy_len, 2*DEPTH + 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we, "R7 reset state", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_full_recall();
    clr_mon();
    first_five();
    chk(!busy, "R1 no start after five", busy, 0);
    host_read(13'h0F0E, 1'b0);
    chk(busy, "R1 busy after sixth read", busy, 1);
    wait_recall();
    check_recall("first");
    host_write(13'h0123, 8'hA5, 1'b1);
  endtask

  task automatic t_wrong_addr();
    host_read(13'h0000, 1'b0);
    host_read(13'h1555, 1'b0);
    host_read(13'h0AAB, 1'b0);
    host_read(13'h1FFF, 1'b0);
    host_read(13'h10F0, 1'b0);
    host_read(13'h0F0E, 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy, "R2 wrong address aborts", busy, 0);
  endtask

  task automatic t_restart_head();
    clr_mon();
    host_read(13'h0000, 1'b0);
    host_read(13'h1555, 1'b0);
    host_read(13'h0000, 1'b0);
    host_read(13'h1555, 1'b0);
    host_read(13'h0AAA, 1'b0);
    host_read(13'h1FFF, 1'b0);
    host_read(13'h10F0, 1'b0);
    host_read(13'h0F0E, 1'b0);
    chk(busy, "R2 head address restarts at step one", busy, 1);
    wait_recall();
    check_recall("restart");
  endtask

  task automatic t_write_abort();
    host_read(13'h0000, 1'b0);
    host_read(13'h1555, 1'b0);
    host_write(13'h0AAA, 8'h3C, 1'b1);
    host_read(13'h0AAA, 1'b0);
    host_read(13'h1FFF, 1'b0);
    host_read(13'h10F0, 1'b0);
    host_read(13'h0F0E, 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy, "R3 write aborts sequence", busy, 0);
  endtask

  task automatic t_busy_lockout();
    clr_mon();
    first_five();
    host_read(13'h0F0E, 1'b0);
    chk(busy, "R1 busy for lockout test", busy, 1);
    host_write(13'h0040, 8'hEE, 1'b0);
    @(negedge clk); ce_n = 1'b0; addr = 13'h0010;
    @(negedge clk);
    chk(host_rdata == 8'h00, "R8 host read blocked", host_rdata, 0);
    ce_n = 1'b1;
    host_read(13'h0000, 1'b0);
    host_read(13'h1555, 1'b0);
    host_read(13'h0AAA, 1'b0);
    host_read(13'h1FFF, 1'b0);
    host_read(13'h10F0, 1'b0);
    wait_recall();
    check_recall("lockout R8");
    host_read(13'h0F0E, 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy, "R8 reads during busy not counted", busy, 0);
  endtask

  task automatic t_repeat();
    clr_mon();
    first_five();
    host_read(13'h0F0E, 1'b0);
    wait_recall();
    check_recall("repeat R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_full_recall();
    t_wrong_addr();
    t_restart_head();
    t_write_abort();
    t_busy_lockout();
    t_repeat();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule